// File: doc/BRIEF.md
# Packed Word FIFO Pair with Service Flags

This block holds the data path between a 32-bit register port and a serial shift engine. It has one FIFO toward the engine for transmit and one FIFO from the engine for receive. Each entry is a serial word of 1, 2 or 4 bytes. Software writes transmit words into a port address with the first byte in the top byte lane. The engine receives each word aligned to the bottom lane. Received words are stored aligned to the bottom lane, and the unused upper bytes are forced to zero.

Software starts a transfer by writing the word count and the word size to one register. The block then picks how the transfer is serviced. FIFO mode is used when the whole count fits in the receive FIFO. Block mode is used otherwise, and service is requested once for each completed block. The block reports the chosen mode and the capacity of each FIFO. Capacity is given as encoded block-size and FIFO-size fields, set by parameters. The matching pair of count registers reports the count, and the other pair reads zero.

The block keeps two flag registers. One holds the live occupancy flags plus sticky service and completion flags. The other holds sticky overrun and underrun errors. Writing a 1 to a sticky bit clears it. The serial shifting and the interrupt controller are outside this block.

Top module: `wfifo_pair`

## Requirements
- R1: After reset both FIFOs are empty, the transfer register (address 0) reads 0, the flag registers (addresses 2 and 3) read 0, and `eng_tx_data` is 0.
- R2: The block size is 4 words when its 2-bit code is 0, and otherwise the code times 16 words. The FIFO depth is the block size times (2 shifted left by the 3-bit FIFO-size code). Address 1 reports the codes in these fields: output block code in [1:0], output FIFO code in [4:2], input block code in [6:5], input FIFO code in [9:7]. A FIFO reports full after exactly depth words are held.
- R3: A write to address 0 sets the word count in [15:0] and the size code in [17:16]. If the count is no larger than the input FIFO depth, FIFO mode is used: mode code 0 in both address-1 fields [13:12] (input) and [11:10] (output). In FIFO mode, addresses 4 and 5 read the count and addresses 6 and 7 read 0. Otherwise block mode is used: mode code 1, addresses 6 and 7 read the count, and addresses 4 and 5 read 0.
- R4: The size code selects the word size: 0 for 1 byte, 1 for 2 bytes, 2 or 3 for 4 bytes. A word written at address 8 reaches the engine with its top N bytes moved to the bottom of `eng_tx_data` and the rest zero.
- R5: A word pushed by the engine keeps only its low N bytes, with the upper bytes zero. A read at address 9 returns the oldest such word and removes it.
- R6: Address 2 shows live occupancy in these bits: bit 4 output not empty, bit 5 input not empty, bit 6 output full, bit 7 input full.
- R7: Service flags sit at address 2: output in bit 8, input in bit 9. In FIFO mode, output service sets when an engine pop empties the output FIFO and no write arrives in the same cycle. In FIFO mode, input service sets when the received word count reaches the programmed count. In block mode, each flag sets once for every block-size words that direction has moved.
- R8: Completion flags sit at address 2: output in bit 10, input in bit 11. Each sets when that direction's moved word count reaches the programmed count.
- R9: Error flags sit at address 3. Bit 2 is input overrun: an engine push while the input FIFO is full. Bit 3 is output underrun: an engine pop while the output FIFO is empty. Bit 4 is input underrun: a read at address 9 while the input FIFO is empty. Bit 5 is output overrun: a write at address 8 while the output FIFO is full. A refused access leaves the FIFO unchanged.
- R10: Writing 1 to a sticky bit of address 2 or 3 clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R11: A write to address 0 empties both FIFOs, clears the moved-word counters, and clears all sticky flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the input FIFO at address 9) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Head transmit word, bottom-aligned |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word, bottom-aligned |

## Verification
Two functions can meet in the same cycle: a software write-one clear of a service flag, and the engine pop that sets that flag again. The bench drives this in block mode. After one block has already set output service, it pops the last word of the next block in the very cycle that clears that bit, then reads address 2 and expects the bit still set. A clear with no set event in its cycle is then checked to drop the bit, so the priority is judged from both sides.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;

  // address map (word addresses)
  localparam logic [3:0] A_XFER   = 4'd0;
  localparam logic [3:0] A_MODE   = 4'd1;
  localparam logic [3:0] A_OPFLG  = 4'd2;
  localparam logic [3:0] A_ERRFLG = 4'd3;
  localparam logic [3:0] A_RDCNT  = 4'd4;
  localparam logic [3:0] A_WRCNT  = 4'd5;
  localparam logic [3:0] A_INCNT  = 4'd6;
  localparam logic [3:0] A_OUTCNT = 4'd7;
  localparam logic [3:0] A_TXPORT = 4'd8;
  localparam logic [3:0] A_RXPORT = 4'd9;

  localparam int unsigned SZ_LSB = 16;

  typedef enum logic [1:0] {
    SVC_FIFO  = 2'd0,
    SVC_BLOCK = 2'd1
  } svc_mode_e;

  // words per block from the 2-bit code
  function automatic int unsigned blk_words(input int unsigned code);
    return (code == 0) ? 4 : code * 16;
  endfunction

  // FIFO depth from block size and 3-bit code
  function automatic int unsigned fifo_words(input int unsigned blk, input int unsigned code);
    return blk * (2 << code);
  endfunction

  // transmit: top bytes of a left-justified word moved to the bottom
  function automatic logic [31:0] tx_align(input logic [31:0] w, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, w[31:24]};
      2'd1:    return {16'h0, w[31:16]};
      default: return w;
    endcase
  endfunction

  // receive: keep the low bytes of the word size
  function automatic logic [31:0] rx_trim(input logic [31:0] w, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, w[7:0]};
      2'd1:    return {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/wfifo_store.sv
module wfifo_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         push_ok,
  output logic         pop_ok
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [LW-1:0] level;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = empty ? '0 : mem[rptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/wfifo_flags.sv
module wfifo_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_all,
  input  logic [N-1:0] set_vec,
  input  logic         w1c_en,
  input  logic [N-1:0] w1c_mask,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              q[i] <= 1'b0;
      else if (clear_all)      q[i] <= 1'b0;
      else if (set_vec[i])     q[i] <= 1'b1;
      else if (w1c_en && w1c_mask[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/wfifo_dircnt.sv
module wfifo_dircnt #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BLK   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] target,
  output logic             reach,
  output logic             blk_end
);
  localparam int unsigned BW = $clog2(BLK);

  logic [CNT_W-1:0] moved;
  logic [BW-1:0]    in_blk;

  assign reach   = step && ((CNT_W+1)'(moved) + (CNT_W+1)'(1) == (CNT_W+1)'(target));
  assign blk_end = step && (in_blk == BW'(BLK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moved  <= '0;
      in_blk <= '0;
    end else if (restart) begin
      moved  <= '0;
      in_blk <= '0;
    end else if (step) begin
      moved  <= moved + 1'b1;
      in_blk <= (in_blk == BW'(BLK - 1)) ? '0 : in_blk + 1'b1;
    end
  end
endmodule

// File: rtl/wfifo_pair.sv
module wfifo_pair
  import wfifo_pkg::*;
#(
  parameter int unsigned OUT_BLK_CODE  = 0,
  parameter int unsigned OUT_FIFO_CODE = 0,
  parameter int unsigned IN_BLK_CODE   = 0,
  parameter int unsigned IN_FIFO_CODE  = 0,
  parameter int unsigned CNT_W         = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        eng_tx_pop,
  output logic [31:0] eng_tx_data,
  input  logic        eng_rx_push,
  input  logic [31:0] eng_rx_data
);
  localparam int unsigned OUT_BLK   = blk_words(OUT_BLK_CODE);
  localparam int unsigned OUT_DEPTH = fifo_words(OUT_BLK, OUT_FIFO_CODE);
  localparam int unsigned IN_BLK    = blk_words(IN_BLK_CODE);
  localparam int unsigned IN_DEPTH  = fifo_words(IN_BLK, IN_FIFO_CODE);

  // register strobes
  logic xfer_wr, out_wr_req, in_rd_req, op_w1c, err_w1c;
  assign xfer_wr    = reg_wr && (reg_addr == A_XFER);
  assign out_wr_req = reg_wr && (reg_addr == A_TXPORT);
  assign in_rd_req  = reg_rd && (reg_addr == A_RXPORT);
  assign op_w1c     = reg_wr && (reg_addr == A_OPFLG);
  assign err_w1c    = reg_wr && (reg_addr == A_ERRFLG);

  // transfer setup
  logic [CNT_W-1:0] count_q;
  logic [1:0]       size_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      size_q  <= '0;
    end else if (xfer_wr) begin
      count_q <= reg_wdata[CNT_W-1:0];
      size_q  <= reg_wdata[SZ_LSB+1:SZ_LSB];
    end
  end

  logic      fifo_mode;
  svc_mode_e svc_mode;
  assign fifo_mode = (32'(count_q) <= IN_DEPTH);
  assign svc_mode  = fifo_mode ? SVC_FIFO : SVC_BLOCK;

  // output FIFO (register port -> engine)
  logic [31:0] out_head;
  logic out_empty, out_full, out_push_ok, out_pop_ok, out_one;
  wfifo_store #(.DEPTH(OUT_DEPTH), .W(32)) u_out (
    .clk(clk), .rst_n(rst_n), .flush(xfer_wr),
    .push(out_wr_req), .pdata(reg_wdata),
    .pop(eng_tx_pop), .head(out_head),
    .empty(out_empty), .full(out_full),
    .push_ok(out_push_ok), .pop_ok(out_pop_ok)
  );

  // track "exactly one word left" for the FIFO-mode empty event
  logic [$clog2(OUT_DEPTH+1)-1:0] out_lvl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_lvl <= '0;
    else if (xfer_wr)  out_lvl <= '0;
    else if (out_push_ok && !out_pop_ok) out_lvl <= out_lvl + 1'b1;
    else if (out_pop_ok && !out_push_ok) out_lvl <= out_lvl - 1'b1;
  end
  assign out_one = (out_lvl == 1);

  assign eng_tx_data = tx_align(out_head, size_q);

  // input FIFO (engine -> register port)
  logic [31:0] in_head;
  logic in_empty, in_full, in_push_ok, in_pop_ok;
  wfifo_store #(.DEPTH(IN_DEPTH), .W(32)) u_in (
    .clk(clk), .rst_n(rst_n), .flush(xfer_wr),
    .push(eng_rx_push), .pdata(rx_trim(eng_rx_data, size_q)),
    .pop(in_rd_req), .head(in_head),
    .empty(in_empty), .full(in_full),
    .push_ok(in_push_ok), .pop_ok(in_pop_ok)
  );

  // moved-word counters
  logic out_reach, out_blk_end, in_reach, in_blk_end;
  wfifo_dircnt #(.CNT_W(CNT_W), .BLK(OUT_BLK)) u_out_cnt (
    .clk(clk), .rst_n(rst_n), .restart(xfer_wr), .step(out_pop_ok),
    .target(count_q), .reach(out_reach), .blk_end(out_blk_end)
  );
  wfifo_dircnt #(.CNT_W(CNT_W), .BLK(IN_BLK)) u_in_cnt (
    .clk(clk), .rst_n(rst_n), .restart(xfer_wr), .step(in_push_ok),
    .target(count_q), .reach(in_reach), .blk_end(in_blk_end)
  );

  // named events
  logic ev_out_svc, ev_in_svc, ev_out_done, ev_in_done;
  logic ev_out_ovr, ev_out_udr, ev_in_ovr, ev_in_udr;
  assign ev_out_svc  = (svc_mode == SVC_FIFO) ? (out_pop_ok && out_one && !out_push_ok)
                                              : out_blk_end;
  assign ev_in_svc   = (svc_mode == SVC_FIFO) ? in_reach : in_blk_end;
  assign ev_out_done = out_reach;
  assign ev_in_done  = in_reach;
  assign ev_out_ovr  = out_wr_req && out_full;
  assign ev_out_udr  = eng_tx_pop && out_empty;
  assign ev_in_ovr   = eng_rx_push && in_full;
  assign ev_in_udr   = in_rd_req && in_empty;

  // sticky flags: op_q = {in done, out done, in svc, out svc} -> bits 11:8
  //               err_q = {out ovr, in udr, out udr, in ovr} -> bits 5:2
  logic [3:0] op_q, err_q;
  wfifo_flags #(.N(4)) u_opf (
    .clk(clk), .rst_n(rst_n), .clear_all(xfer_wr),
    .set_vec({ev_in_done, ev_out_done, ev_in_svc, ev_out_svc}),
    .w1c_en(op_w1c), .w1c_mask(reg_wdata[11:8]), .q(op_q)
  );
  wfifo_flags #(.N(4)) u_errf (
    .clk(clk), .rst_n(rst_n), .clear_all(xfer_wr),
    .set_vec({ev_out_ovr, ev_in_udr, ev_out_udr, ev_in_ovr}),
    .w1c_en(err_w1c), .w1c_mask(reg_wdata[5:2]), .q(err_q)
  );

  // count registers
  logic [31:0] cnt_fifo_v, cnt_blk_v;
  assign cnt_fifo_v = fifo_mode ? 32'(count_q) : 32'h0;
  assign cnt_blk_v  = fifo_mode ? 32'h0 : 32'(count_q);

  // read mux
  always_comb begin
    case (reg_addr)
      A_XFER:   reg_rdata = {14'h0, size_q, 16'h0} | 32'(count_q);
      A_MODE:   reg_rdata = {18'h0, svc_mode, svc_mode, 3'(IN_FIFO_CODE), 2'(IN_BLK_CODE),
                             3'(OUT_FIFO_CODE), 2'(OUT_BLK_CODE)};
      A_OPFLG:  reg_rdata = {20'h0, op_q, in_full, out_full, !in_empty, !out_empty, 4'h0};
      A_ERRFLG: reg_rdata = {26'h0, err_q, 2'b00};
      A_RDCNT,
      A_WRCNT:  reg_rdata = cnt_fifo_v;
      A_INCNT,
      A_OUTCNT: reg_rdata = cnt_blk_v;
      A_RXPORT: reg_rdata = in_head;
      default:  reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/wfifo_pair_chk.sv
module wfifo_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_wr,
  input logic       out_wr_req,
  input logic       out_full,
  input logic       out_empty,
  input logic       out_pop_ok,
  input logic       eng_tx_pop,
  input logic       eng_rx_push,
  input logic       in_full,
  input logic       op_w1c,
  input logic       w1c_bit8,
  input logic       ev_out_svc,
  input logic       ev_out_done,
  input logic [3:0] op_q,
  input logic [3:0] err_q,
  input logic [31:0] cnt_fifo_v,
  input logic [31:0] cnt_blk_v
);
  // R9: write into a full output FIFO flags overrun and leaves it full
  assert_out_ovr_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr_req && out_full && !xfer_wr) |=> err_q[3]);
  assert_out_ovr_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr_req && out_full && !out_pop_ok && !xfer_wr) |=> out_full);
  // R9: engine pop on empty output FIFO flags underrun
  assert_out_udr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_pop && out_empty && !xfer_wr) |=> err_q[1]);
  // R9: engine push into full input FIFO flags overrun
  assert_in_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && in_full && !xfer_wr) |=> err_q[0]);
  // R10: set wins over a same-cycle clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_out_svc && !xfer_wr) |=> op_q[0]);
  // R10: clear without a set event drops the bit
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w1c && w1c_bit8 && !ev_out_svc && !xfer_wr) |=> !op_q[0]);
  // R8: completion event lands in the flag
  assert_out_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_out_done && !xfer_wr) |=> op_q[2]);
  // R11: transfer start clears all sticky flags
  assert_start_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_wr |=> (op_q == 4'h0 && err_q == 4'h0));
  // R3: only one pair of count registers carries the count
  assert_cnt_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fifo_v == 32'h0) || (cnt_blk_v == 32'h0));

  // R2: a FIFO is never full and empty at once
  always @(posedge clk) begin
    if (rst_n) begin
      assert_full_empty_R2: assert (!(out_full && out_empty));
    end
  end
endmodule

bind wfifo_pair wfifo_pair_chk chk_i (
  .clk(clk), .rst_n(rst_n), .xfer_wr(xfer_wr), .out_wr_req(out_wr_req),
  .out_full(out_full), .out_empty(out_empty), .out_pop_ok(out_pop_ok),
  .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .in_full(in_full),
  .op_w1c(op_w1c), .w1c_bit8(reg_wdata[8]), .ev_out_svc(ev_out_svc),
  .ev_out_done(ev_out_done), .op_q(op_q), .err_q(err_q),
  .cnt_fifo_v(cnt_fifo_v), .cnt_blk_v(cnt_blk_v)
);

// File: tb/wfifo_pair_tb.sv
`timescale 1ns/1ps
module wfifo_pair_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 6;

  // packing vectors: size code, tx word, expected engine word, rx word, expected read
  localparam logic [1:0]  V_SZ   [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
  localparam logic [31:0] V_TXW  [NV] = '{32'hA5123456, 32'hBEEF0011, 32'h01234567,
                                          32'h89ABCDEF, 32'h7F000000, 32'h8000FFFF};
  localparam logic [31:0] V_TXE  [NV] = '{32'h000000A5, 32'h0000BEEF, 32'h01234567,
                                          32'h89ABCDEF, 32'h0000007F, 32'h00008000};
  localparam logic [31:0] V_RXW  [NV] = '{32'hDEADBEEF, 32'h12345678, 32'hCAFEF00D,
                                          32'h76543210, 32'h00000180, 32'hFFFF0001};
  localparam logic [31:0] V_RXE  [NV] = '{32'h000000EF, 32'h00005678, 32'hCAFEF00D,
                                          32'h76543210, 32'h00000080, 32'h00000001};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [31:0] eng_tx_data, eng_rx_data = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  wfifo_pair dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic tx_pop(output logic [31:0] d);
    @(negedge clk); eng_tx_pop = 1'b1; #1 d = eng_tx_data;
    @(negedge clk); eng_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  function automatic logic [31:0] xfer(input int cnt, input logic [1:0] sz);
    return (32'(sz) << 16) | 32'(cnt);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v); check("R1 xfer reg", v, 32'h0);
    rd(4'd2, v); check("R1 op flags", v, 32'h0);
    rd(4'd3, v); check("R1 err flags", v, 32'h0);
    check("R1 tx data", eng_tx_data, 32'h0);
    rd(4'd1, v); check("R2 R3 mode reg after reset", v, 32'h0);

    // table walk: R4 transmit alignment, R5 receive trimming
    for (int i = 0; i < NV; i++) begin
      wr(4'd0, xfer(1, V_SZ[i]));
      wr(4'd8, V_TXW[i]);
      tx_pop(v); check($sformatf("R4 tx vec %0d", i), v, V_TXE[i]);
      rx_push(V_RXW[i]);
      rd(4'd9, v); check($sformatf("R5 rx vec %0d", i), v, V_RXE[i]);
    end

    // R3 mode selection at the boundary
    wr(4'd0, xfer(8, 2'd2));
    rd(4'd1, v); check("R3 count 8 mode", v, 32'h0);
    rd(4'd4, v); check("R3 count 8 read cnt", v, 32'd8);
    rd(4'd5, v); check("R3 count 8 write cnt", v, 32'd8);
    rd(4'd6, v); check("R3 count 8 input cnt", v, 32'd0);
    wr(4'd0, xfer(9, 2'd2));
    rd(4'd1, v); check("R3 count 9 mode", v, 32'h1400);
    rd(4'd7, v); check("R3 count 9 output cnt", v, 32'd9);
    rd(4'd4, v); check("R3 count 9 read cnt", v, 32'd0);

    // FIFO mode: R2 capacity, R6 occupancy, R9 overrun, R10 clears
    wr(4'd0, xfer(8, 2'd2));
    for (int i = 0; i < 7; i++) wr(4'd8, 32'h100 + 32'(i));
    rd(4'd2, v); check("R2 R6 seven words not full", v, 32'h10);
    wr(4'd8, 32'h107);
    rd(4'd2, v); check("R2 R6 eight words full", v, 32'h50);
    wr(4'd8, 32'hBAD);
    rd(4'd3, v); check("R9 output overrun", v, 32'h20);
    wr(4'd3, 32'h0);
    rd(4'd3, v); check("R10 write zero keeps error", v, 32'h20);
    wr(4'd3, 32'h20);
    rd(4'd3, v); check("R10 write one clears error", v, 32'h0);
    for (int i = 0; i < 8; i++) begin
      tx_pop(v);
      if (i == 0 || i == 7) check("R9 refused write left data", v, 32'h100 + 32'(i));
    end
    rd(4'd2, v); check("R7 R8 output drained", v, 32'h500);
    tx_pop(v);
    rd(4'd3, v); check("R9 output underrun", v, 32'h08);

    for (int i = 0; i < 8; i++) rx_push(32'hA0 + 32'(i));
    rd(4'd2, v); check("R6 R7 R8 input filled", v, 32'hFA0);
    rx_push(32'hEE);
    rd(4'd3, v); check("R9 input overrun", v, 32'h0C);
    for (int i = 0; i < 8; i++) begin
      rd(4'd9, v);
      if (i == 0 || i == 7) check("R5 R9 input order", v, 32'hA0 + 32'(i));
    end
    rd(4'd9, v); check("R9 empty read data", v, 32'h0);
    rd(4'd3, v); check("R9 input underrun", v, 32'h1C);

    // R11 start clears sticky flags
    wr(4'd0, xfer(20, 2'd2));
    rd(4'd2, v); check("R11 op flags cleared", v, 32'h0);
    rd(4'd3, v); check("R11 err flags cleared", v, 32'h0);

    // block mode: R7 service per block, R8 not yet done
    for (int i = 0; i < 4; i++) wr(4'd8, 32'h200 + 32'(i));
    for (int i = 0; i < 3; i++) tx_pop(v);
    rd(4'd2, v); check("R7 block not complete", v, 32'h10);
    tx_pop(v);
    rd(4'd2, v); check("R7 R8 block service only", v, 32'h100);

    // R10 set and clear in the same cycle: set wins
    for (int i = 0; i < 4; i++) wr(4'd8, 32'h300 + 32'(i));
    for (int i = 0; i < 3; i++) tx_pop(v);
    @(negedge clk);
    eng_tx_pop = 1'b1; reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'h100;
    @(negedge clk);
    eng_tx_pop = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(4'd2, v); check("R10 set wins over clear", v, 32'h100);
    wr(4'd2, 32'h100);
    rd(4'd2, v); check("R10 plain clear", v, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule